// File: doc/BRIEF.md
# Bad Block Table Scanner

This controller sits on the host side of a NAND array and, on request, builds a table of the blocks that left the factory marked as unusable. After a start pulse it walks the blocks in ascending address order, starting at block zero. For each block it reads one marker byte from the first page and then one from the second page. The reads go over a simple request/response memory port. That port stands in for the pin-level flash sequencing, which lives elsewhere.

An erased marker reads as FFh. Any other value on either page, including the factory 00h mark, flags the block as bad. Block zero is always treated as usable. The result lands in an internal bitmap, one bit per block, which a combinational read port exposes. A bad-block count and a one-cycle done pulse close the scan. The block only ever issues reads, so the factory marks cannot be disturbed.

Top module: `bbt_scan`

## Requirements
- R1: Out of reset, busy_o, done_o and req_valid_o are low, bad_count_o is zero and every bitmap bit reads 0.
- R2: A scan issues exactly two reads per block, for blocks 0 up to NUM_BLOCKS-1 in ascending order. Within a block the page 0 read comes before the page 1 read. Each request carries req_row_o = block*PAGES_PER_BLOCK + page (block in the upper bits, page in the low log2(PAGES_PER_BLOCK) bits) and req_col_o = MARK_COL.
- R3: While req_valid_o is high and req_ready_i is low, req_valid_o stays high and req_row_o does not change.
- R4: A block other than 0 is recorded bad (bitmap bit 1) when the byte returned for page 0 or for page 1 is anything other than FFh. This covers 00h as well as other values.
- R5: A block whose page 0 and page 1 bytes both read FFh is recorded valid (bitmap bit 0).
- R6: Block 0 always reads valid in the bitmap, whatever its marker bytes hold.
- R7: done_o is high for exactly one cycle: the cycle after the clock edge that accepts the last block's page 1 response. In that cycle busy_o is low, and bad_count_o equals the number of bitmap bits set.
- R8: A start_i pulse during a scan is ignored. The scan continues in its original order and ends with one done pulse.
- R9: Starting a new scan clears all bitmap bits and the count before blocks are re-evaluated.
- R10: At most one read is outstanding. No new request is accepted before the previous request's response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at scan end |
| bad_count_o | output | $clog2(NUM_BLOCKS+1) (10) | Number of blocks recorded bad |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_row_o | output | log2(NUM_BLOCKS)+log2(PAGES_PER_BLOCK) (13) | Page address of the read |
| req_col_o | output | $clog2(PAGE_BYTES) (9) | Column of the marker byte |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 8 | Read data byte |
| bm_addr_i | input | log2(NUM_BLOCKS) (9) | Bitmap read address |
| bm_bad_o | output | 1 | Bitmap bit for bm_addr_i, 1 = bad |

## Verification
A request is accepted on the edge where valid and ready are both high. The response is taken on the edge where rsp_valid_i is high. The bitmap bit and the count update on that same edge, and done_o rises in the following cycle. The bench memory model drives and samples only just after falling edges. It records the cycle in which it drove the final response and requires done_o exactly one cycle later, then low again a cycle after that. Request order, hold-during-stall and overlap are checked at every falling edge. The bitmap is swept through the read port only once the scan is idle, so every read is of settled state.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} scan_st_e;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/bbt_seq.sv
module bbt_seq
  import bbt_pkg::*;
#(
  parameter int NUM_BLOCKS = 512,
  parameter int BLK_W      = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             req_valid_o,
  output logic             clear_o,
  output logic             rsp_fire_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             page_o
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_st_e         st_q, st_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             pg_q, pg_d;

  always_comb begin
    st_d  = st_q;
    blk_d = blk_q;
    pg_d  = pg_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_REQ;
        blk_d = '0;
        pg_d  = 1'b0;
      end
      ST_REQ: if (req_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) begin
        if (!pg_q) begin
          pg_d = 1'b1;
          st_d = ST_REQ;
        end else if (blk_q == LAST_BLK) begin
          st_d = ST_DONE;
        end else begin
          blk_d = blk_q + 1'b1;
          pg_d  = 1'b0;
          st_d  = ST_REQ;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      blk_q <= '0;
      pg_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      blk_q <= blk_d;
      pg_q  <= pg_d;
    end
  end

  assign busy_o      = (st_q == ST_REQ) || (st_q == ST_WAIT);
  assign done_o      = (st_q == ST_DONE);
  assign req_valid_o = (st_q == ST_REQ);
  assign clear_o     = (st_q == ST_IDLE) && start_i;
  assign rsp_fire_o  = (st_q == ST_WAIT) && rsp_valid_i;
  assign blk_o       = blk_q;
  assign page_o      = pg_q;

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(blk_o) && $stable(page_o));

  a_r2_blk_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fire_o && page_o && (blk_o != LAST_BLK) |=> (blk_o == $past(blk_o) + 1'b1) && !page_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: rtl/bbt_mark.sv
module bbt_mark
  import bbt_pkg::*;
#(
  parameter int BLK_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             fire_i,
  input  logic             page_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [7:0]       data_i,
  output logic             commit_o,
  output logic             commit_bad_o
);
  logic pend_bad_q;
  logic hit;

  assign hit = (data_i != ERASED_BYTE);

  // page 0 verdict is held until the page 1 byte arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_bad_q <= 1'b0;
    else if (clear_i)            pend_bad_q <= 1'b0;
    else if (fire_i && !page_i)  pend_bad_q <= hit;
  end

  assign commit_o     = fire_i && page_i;
  assign commit_bad_o = (pend_bad_q || hit) && (blk_i != '0);
endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
  parameter int NUM_BLOCKS = 512,
  parameter int BLK_W      = 9,
  parameter int CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             commit_i,
  input  logic             bad_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] rd_addr_i,
  output logic             rd_bad_o,
  output logic [CNT_W-1:0] count_o
);
  logic [NUM_BLOCKS-1:0] bits_q;
  logic [CNT_W-1:0]      count_q;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                             bits_q[g] <= 1'b0;
      else if (clear_i)                                        bits_q[g] <= 1'b0;
      else if (commit_i && bad_i && (blk_i == BLK_W'(g)))      bits_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  count_q <= '0;
    else if (clear_i)             count_q <= '0;
    else if (commit_i && bad_i)   count_q <= count_q + 1'b1;
  end

  assign rd_bad_o = (int'(rd_addr_i) < NUM_BLOCKS) ? bits_q[rd_addr_i] : 1'b0;
  assign count_o  = count_q;

  a_r6_blk0_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q[0] == 1'b0);

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= NUM_BLOCKS - 1);
endmodule

// File: rtl/bbt_scan.sv
module bbt_scan #(
  parameter int NUM_BLOCKS      = 512,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int PAGE_BYTES      = 264,
  parameter int MARK_COL        = 256,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] bad_count_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [ROW_W-1:0] req_row_o,
  output logic [COL_W-1:0] req_col_o,
  input  logic             rsp_valid_i,
  input  logic [7:0]       rsp_data_i,
  input  logic [BLK_W-1:0] bm_addr_i,
  output logic             bm_bad_o
);
  logic             clear, rsp_fire, page;
  logic [BLK_W-1:0] blk;
  logic             commit, commit_bad;

  bbt_seq #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .req_ready_i, .rsp_valid_i,
    .busy_o, .done_o, .req_valid_o,
    .clear_o(clear), .rsp_fire_o(rsp_fire), .blk_o(blk), .page_o(page)
  );

  bbt_mark #(.BLK_W(BLK_W)) i_mark (
    .clk_i, .rst_ni, .clear_i(clear), .fire_i(rsp_fire), .page_i(page),
    .blk_i(blk), .data_i(rsp_data_i), .commit_o(commit), .commit_bad_o(commit_bad)
  );

  bbt_bitmap #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .CNT_W(CNT_W)) i_bitmap (
    .clk_i, .rst_ni, .clear_i(clear), .commit_i(commit), .bad_i(commit_bad),
    .blk_i(blk), .rd_addr_i(bm_addr_i), .rd_bad_o(bm_bad_o), .count_o(bad_count_o)
  );

  assign req_row_o = {blk, PG_W'(page)};
  assign req_col_o = COL_W'(MARK_COL);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  a_r2_page_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> int'(req_row_o[PG_W-1:0]) <= 1);
endmodule

// File: tb/test_bbt_scan.sv
module test_bbt_scan;
  localparam int NB = 512, PPB = 16, MC = 256;
  localparam int BLK_W = 9, PG_W = 4, ROW_W = 13, COL_W = 9, CNT_W = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             busy_o, done_o, req_valid_o, bm_bad_o;
  logic [CNT_W-1:0] bad_count_o;
  logic             req_ready_i = 1'b0;
  logic [ROW_W-1:0] req_row_o;
  logic [COL_W-1:0] req_col_o;
  logic             rsp_valid_i = 1'b0;
  logic [7:0]       rsp_data_i = 8'h00;
  logic [BLK_W-1:0] bm_addr_i = '0;

  bbt_scan i_bbt_scan (
    .clk_i(clk), .rst_ni, .start_i, .busy_o, .done_o, .bad_count_o,
    .req_valid_o, .req_ready_i, .req_row_o, .req_col_o,
    .rsp_valid_i, .rsp_data_i, .bm_addr_i, .bm_bad_o
  );

  int n_tests = 0, n_fail = 0;
  int pat = 0, cyc = 0;
  bit stall_en = 0;
  bit pend = 0;
  int lat = 0;
  logic [ROW_W-1:0] cap_row, prev_row;
  logic [COL_W-1:0] cap_col;
  int exp_idx = 0, order_err = 0, hold_err = 0, overlap_err = 0, last_rsp_cyc = -10;
  bit prev_wait = 0;

  function automatic logic [7:0] mark_byte(int p, int b, int g);
    case (p)
      1: begin
        if (b == 0 && g == 0) return 8'h00;
        if (b == 1 && g == 0) return 8'h00;
        if (b == 2 && g == 1) return 8'h00;
        if (b == 3 && g == 0) return 8'h5A;
        if (b == 511)         return 8'h00;
        return 8'hFF;
      end
      2: return (b % 5 == 0 && g == 1) ? 8'h00 : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit exp_bad(int p, int b);
    return (b != 0) && (mark_byte(p, b, 0) != 8'hFF || mark_byte(p, b, 1) != 8'hFF);
  endfunction

  // memory model: acts only at falling edges
  always @(negedge clk) begin
    cyc++;
    if (prev_wait && (!req_valid_o || req_row_o != prev_row)) hold_err++;
    rsp_valid_i = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        rsp_valid_i = 1'b1;
        rsp_data_i = (int'(cap_col) == MC && int'(cap_row[PG_W-1:0]) <= 1)
                   ? mark_byte(pat, int'(cap_row >> PG_W), int'(cap_row[PG_W-1:0])) : 8'h00;
        pend = 0;
        last_rsp_cyc = cyc;
      end else lat--;
    end
    req_ready_i = stall_en ? (cyc % 3 != 0) : 1'b1;
    prev_wait = req_valid_o && !req_ready_i;
    prev_row  = req_row_o;
    if (req_valid_o && req_ready_i) begin
      if (pend) overlap_err++;
      if (req_row_o != ROW_W'((exp_idx / 2) * PPB + (exp_idx % 2))) order_err++;
      exp_idx++;
      cap_row = req_row_o;
      cap_col = req_col_o;
      pend = 1;
      lat = stall_en ? 2 : 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic sweep_map(input int p, input string rq);
    int mism = 0;
    for (int b = 0; b < NB; b++) begin
      bm_addr_i = BLK_W'(b); #1;
      if (bm_bad_o != exp_bad(p, b)) mism++;
    end
    chk(mism == 0, rq, "bitmap mismatches", mism, 0);
  endtask

  function automatic int exp_count(int p);
    int c = 0;
    for (int b = 0; b < NB; b++) if (exp_bad(p, b)) c++;
    return c;
  endfunction

  task automatic run_scan(input int p, input bit st, input bit poke);
    int n = 0;
    pat = p; stall_en = st;
    exp_idx = 0; order_err = 0; hold_err = 0; overlap_err = 0;
    step(); start_i = 1'b1;
    step(); start_i = 1'b0;
    if (poke) begin
      repeat (50) step();
      chk(busy_o == 1'b1, "R8", "busy before extra start", busy_o, 1);
      start_i = 1'b1; step(); start_i = 1'b0;
    end
    while (!done_o && n < 40000) begin step(); n++; end
    chk(done_o == 1'b1, "R7", "done seen", done_o, 1);
    chk(last_rsp_cyc == cyc - 1, "R7", "done delay after last response", cyc - last_rsp_cyc, 1);
    chk(busy_o == 1'b0, "R7", "busy during done", busy_o, 0);
    chk(int'(bad_count_o) == exp_count(p), "R7", "bad count", bad_count_o, exp_count(p));
    step();
    chk(done_o == 1'b0, "R7", "done width", done_o, 0);
    chk(order_err == 0, "R2", "request order errors", order_err, 0);
    chk(exp_idx == 2 * NB, "R2", "request total", exp_idx, 2 * NB);
    chk(hold_err == 0, "R3", "hold violations", hold_err, 0);
    chk(overlap_err == 0, "R10", "overlapping requests", overlap_err, 0);
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    chk(req_valid_o == 1'b0, "R1", "req_valid after reset", req_valid_o, 0);
    chk(bad_count_o == '0, "R1", "count after reset", bad_count_o, 0);
    sweep_map(0, "R1");
  endtask

  task automatic t_all_erased();
    run_scan(0, 0, 0);
    sweep_map(0, "R5");
    chk(bad_count_o == '0, "R5", "count all erased", bad_count_o, 0);
  endtask

  task automatic t_mixed_marks();
    run_scan(1, 0, 0);
    sweep_map(1, "R4");
    bm_addr_i = 9'd0; #1;   chk(bm_bad_o == 1'b0, "R6", "block 0 forced valid", bm_bad_o, 0);
    bm_addr_i = 9'd1; #1;   chk(bm_bad_o == 1'b1, "R4", "page0 00h", bm_bad_o, 1);
    bm_addr_i = 9'd2; #1;   chk(bm_bad_o == 1'b1, "R4", "page1 00h", bm_bad_o, 1);
    bm_addr_i = 9'd3; #1;   chk(bm_bad_o == 1'b1, "R4", "page0 5Ah", bm_bad_o, 1);
    bm_addr_i = 9'd511; #1; chk(bm_bad_o == 1'b1, "R4", "last block", bm_bad_o, 1);
    bm_addr_i = 9'd4; #1;   chk(bm_bad_o == 1'b0, "R5", "erased block 4", bm_bad_o, 0);
    chk(int'(bad_count_o) == 4, "R4", "mixed count", bad_count_o, 4);
  endtask

  task automatic t_stalled();
    run_scan(2, 1, 0);
    sweep_map(2, "R4");
    chk(int'(bad_count_o) == 102, "R6", "count with block 0 excluded", bad_count_o, 102);
  endtask

  task automatic t_start_while_busy();
    run_scan(1, 0, 1);
    sweep_map(1, "R8");
    repeat (5) begin
      step();
      chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "no second scan", {busy_o, done_o}, 0);
    end
  endtask

  task automatic t_rescan_clears();
    run_scan(2, 0, 0);
    run_scan(0, 0, 0);
    sweep_map(0, "R9");
    chk(bad_count_o == '0, "R9", "count after rescan", bad_count_o, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_all_erased();
    t_mixed_marks();
    t_stalled();
    t_start_while_busy();
    t_rescan_clears();
    finish_run();
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule